// File: doc/BRIEF.md
# Arbitrated Local Memory Access Port

This block connects a host CPU data port and a network DMA engine to one shared single-port local memory. The host sees a pointer register and a data port. Host writes are posted into a one-entry holding register and committed to memory in the gaps between host cycles. Host reads are answered at once from a prefetch register that is refilled in the background for the next address. A one-cycle-per-access memory sequence lets a host transfer repeat every 3 clocks with no added wait states while the DMA engine is quiet.

A two-way arbiter hands each memory clock to either the host path or the DMA path. A granted access is never taken away. A requester that was held off is served in the very next memory clock. When both requesters arrive fresh on an idle memory, the host path wins. Inside the host path, the prefetch for the next address goes ahead of a posted write, unless both target the same word. In that case the write commits first, so that the prefetch returns the new data.

Top module: `lmem_port`

## Requirements
- R1: While rst_ni is low, host_rdy_o and mem_req_o are 0. After reset the pointer is 0, and host_rdy_o rises once the word at address 0 has been prefetched.
- R2: A host write accepted while host_rdy_o is 1 is written to memory at the current pointer, and the pointer then advances by 1, wrapping at the address width.
- R3: A host read accepted while host_rdy_o is 1 returns, on host_rdata_o in that same clock, the memory word at the current pointer. The pointer then advances by 1, and the word at the new pointer is prefetched.
- R4: With no DMA traffic, host_rdy_o is 0 for the two clocks after an accepted host read or write and is 1 again in the third clock, giving a 3-clock host transfer.
- R5: When the host path and the DMA path both request in the same clock and neither was held off before, the host path is granted and dma_gnt_o stays 0.
- R6: A requester held off in one clock is granted in the next clock. This applies to the DMA path when the host path took the memory, and to the host path when the DMA path took it.
- R7: When a posted write and a prefetch target the same address, the write reaches memory first, and the following host read returns the written value.
- R8: Writing the pointer (host_addr_we_i) discards the prefetched word. host_rdy_o is 0 in the next clock, and the next host read returns the word at the new address.
- R9: A host read or write strobe given while host_rdy_o is 0 is ignored. Neither memory nor the pointer changes.
- R10: A granted DMA access drives the memory in the grant clock with the DMA address, write enable and data. For a read, dma_rvalid_o is 1 in the next clock with the word on dma_rdata_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_we_i | input | 1 | Load the host pointer |
| host_addr_i | input | AW | New pointer value |
| host_wr_i | input | 1 | Host data-port write strobe |
| host_wdata_i | input | DW | Host write data |
| host_rd_i | input | 1 | Host data-port read strobe |
| host_rdata_o | output | DW | Prefetched word at the pointer |
| host_rdy_o | output | 1 | Data port can accept a strobe |
| dma_req_i | input | 1 | DMA access request, held until granted |
| dma_we_i | input | 1 | DMA access is a write |
| dma_addr_i | input | AW | DMA address |
| dma_wdata_i | input | DW | DMA write data |
| dma_gnt_o | output | 1 | DMA access issued this clock |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | DW | DMA read data |
| mem_req_o | output | 1 | Memory access this clock |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, valid the clock after a read |

## Verification
The bench targets the ordering hazards. In one case the pointer is rewritten to the word whose write is still posted. A design that fetched first would return the old contents. In another, the pointer is rewritten while a prefetch is still in flight. A design that kept that returning word would hand back data from the wrong address. A strobe given while the port is busy is checked through the next read and the memory contents; a design that accepted it would move the pointer or corrupt a word. Contended clocks are checked one by one: fresh requests that arrive together must go to the host path, and each held-off side must win the following clock. A design with fixed priority would starve the DMA path. A design without priority would make the host path miss its 3-clock cadence.

// File: rtl/lmp_pkg.sv
package lmp_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_CPU_RD = 2'd1,
    SRC_DMA_RD = 2'd2
  } rd_src_e;
endpackage

// File: rtl/lmp_arb.sv
module lmp_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic dma_req_i,
  output logic cpu_gnt_o,
  output logic dma_gnt_o
);
  logic cpu_wait_q, dma_wait_q;

  // fresh collision goes to the cpu path; a held-off side wins next clock
  assign dma_gnt_o = dma_req_i && (!cpu_req_i || dma_wait_q);
  assign cpu_gnt_o = cpu_req_i && !dma_gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_wait_q <= 1'b0;
      dma_wait_q <= 1'b0;
    end else begin
      cpu_wait_q <= cpu_req_i && !cpu_gnt_o;
      dma_wait_q <= dma_req_i && !dma_gnt_o;
    end
  end

  a_r6_dma_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i && !dma_gnt_o |=> !dma_req_i || dma_gnt_o);
  a_r6_cpu_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_gnt_o |=> cpu_gnt_o);
  a_r5_cpu_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && dma_req_i && !cpu_wait_q && !dma_wait_q |-> !dma_gnt_o);
endmodule

// File: rtl/lmp_host.sv
module lmp_host #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdy_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] maddr_o,
  output logic [DW-1:0] mwdata_o,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i
);
  logic [AW-1:0] ptr_q, wb_a_q;
  logic [DW-1:0] wb_d_q, pf_d_q;
  logic          wb_v_q, pf_v_q, need_q;
  logic          acc_wr, acc_rd, host_evt, hit, do_fetch, take;

  assign rdy_o    = pf_v_q && !wb_v_q;
  assign rdata_o  = pf_d_q;
  assign acc_wr   = wr_i && rdy_o;
  assign acc_rd   = rd_i && rdy_o && !wr_i;
  assign host_evt = addr_we_i || acc_wr || acc_rd;

  // fetch goes first unless it would read the word still posted
  assign hit      = wb_v_q && (wb_a_q == ptr_q);
  assign do_fetch = need_q && !hit;
  assign req_o    = wb_v_q || need_q;
  assign we_o     = !do_fetch;
  assign maddr_o  = do_fetch ? ptr_q : wb_a_q;
  assign mwdata_o = wb_d_q;
  // a return is dropped if the pointer moved since it was issued
  assign take     = rvalid_i && !need_q && !host_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wb_a_q <= '0;
      wb_d_q <= '0;
      wb_v_q <= 1'b0;
      pf_d_q <= '0;
      pf_v_q <= 1'b0;
      need_q <= 1'b1;
    end else begin
      if (addr_we_i)             ptr_q <= addr_i;
      else if (acc_wr || acc_rd) ptr_q <= ptr_q + 1'b1;

      if (acc_wr) begin
        wb_v_q <= 1'b1;
        wb_a_q <= ptr_q;
        wb_d_q <= wdata_i;
      end else if (gnt_i && !do_fetch) begin
        wb_v_q <= 1'b0;
      end

      if (host_evt)                 need_q <= 1'b1;
      else if (gnt_i && do_fetch)   need_q <= 1'b0;

      if (host_evt)  pf_v_q <= 1'b0;
      else if (take) pf_v_q <= 1'b1;
      if (take)      pf_d_q <= rdata_i;
    end
  end

  a_r9_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && !rdy_o && !addr_we_i |=> ptr_q == $past(ptr_q));
  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && rdy_o && !addr_we_i |=> ptr_q == AW'($past(ptr_q) + 1'b1));
  a_r8_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |=> !rdy_o);
  a_r7_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i && !we_o |-> !(wb_v_q && wb_a_q == maddr_o));
endmodule

// File: rtl/lmem_port.sv
module lmem_port #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_addr_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_rdy_o,
  input  logic          dma_req_i,
  input  logic          dma_we_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic          dma_gnt_o,
  output logic          dma_rvalid_o,
  output logic [DW-1:0] dma_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  import lmp_pkg::*;

  logic          cpu_req, cpu_gnt, cpu_we, cpu_rvalid;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  rd_src_e       rd_src_q;

  lmp_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_req_i (cpu_req),
    .dma_req_i (dma_req_i),
    .cpu_gnt_o (cpu_gnt),
    .dma_gnt_o (dma_gnt_o)
  );

  lmp_host #(.AW(AW), .DW(DW)) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (host_addr_we_i),
    .addr_i    (host_addr_i),
    .wr_i      (host_wr_i),
    .wdata_i   (host_wdata_i),
    .rd_i      (host_rd_i),
    .rdata_o   (host_rdata_o),
    .rdy_o     (host_rdy_o),
    .req_o     (cpu_req),
    .we_o      (cpu_we),
    .maddr_o   (cpu_addr),
    .mwdata_o  (cpu_wdata),
    .gnt_i     (cpu_gnt),
    .rvalid_i  (cpu_rvalid),
    .rdata_i   (mem_rdata_i)
  );

  assign mem_req_o   = rst_ni && (cpu_gnt || dma_gnt_o);
  assign mem_we_o    = dma_gnt_o ? dma_we_i    : cpu_we;
  assign mem_addr_o  = dma_gnt_o ? dma_addr_i  : cpu_addr;
  assign mem_wdata_o = dma_gnt_o ? dma_wdata_i : cpu_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rd_src_q <= SRC_IDLE;
    else if (dma_gnt_o && !dma_we_i)   rd_src_q <= SRC_DMA_RD;
    else if (cpu_gnt && !cpu_we)       rd_src_q <= SRC_CPU_RD;
    else                               rd_src_q <= SRC_IDLE;
  end

  assign cpu_rvalid   = (rd_src_q == SRC_CPU_RD);
  assign dma_rvalid_o = (rd_src_q == SRC_DMA_RD);
  assign dma_rdata_o  = mem_rdata_i;

  a_r10_dma_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o |-> mem_req_o && mem_addr_o == dma_addr_i && mem_we_o == dma_we_i);
  a_r10_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o && !dma_we_i |=> dma_rvalid_o);
endmodule

// File: tb/lmem_port_bench.sv
module lmem_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_addr_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic          host_rdy;
  logic          dma_req = 1'b0, dma_we = 1'b0, dma_gnt, dma_rvalid;
  logic [AW-1:0] dma_addr = '0;
  logic [DW-1:0] dma_wdata = '0, dma_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] host_q[$];
  logic [DW-1:0] dma_q[$];
  int            n_chk = 0, n_fail = 0;
  logic [AW-1:0] hp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmem_port #(.AW(AW), .DW(DW)) u_lmem_port (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_we_i(host_addr_we), .host_addr_i(host_addr),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rd_i(host_rd), .host_rdata_o(host_rdata), .host_rdy_o(host_rdy),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr),
    .dma_wdata_i(dma_wdata), .dma_gnt_o(dma_gnt),
    .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // single-port memory, read data one clock after the request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    #2;
    if (rst_n && host_rd && !host_wr && host_rdy) begin
      if (host_q.size() == 0) chk(1'b0, "R3 unexpected host read", 32'(host_rdata), 0);
      else begin
        logic [DW-1:0] e;
        e = host_q.pop_front();
        chk(host_rdata == e, "R3 host read data", 32'(host_rdata), 32'(e));
      end
    end
    if (rst_n && dma_rvalid) begin
      if (dma_q.size() == 0) chk(1'b0, "R10 unexpected dma rvalid", 32'(dma_rdata), 0);
      else begin
        logic [DW-1:0] e;
        e = dma_q.pop_front();
        chk(dma_rdata == e, "R10 dma read data", 32'(dma_rdata), 32'(e));
      end
    end
  end

  task automatic wait_rdy();
    do @(negedge clk); while (!host_rdy);
  endtask

  task automatic host_read();
    wait_rdy();
    host_q.push_back(ref_mem[hp]);
    hp = hp + 1'b1;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [DW-1:0] d);
    wait_rdy();
    ref_mem[hp] = d;
    hp = hp + 1'b1;
    host_wr = 1'b1;
    host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_set(input logic [AW-1:0] a);
    @(negedge clk);
    host_addr_we = 1'b1;
    host_addr = a;
    hp = a;
    @(negedge clk);
    host_addr_we = 1'b0;
  endtask

  task automatic dma_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    dma_req = 1'b1; dma_we = we; dma_addr = a; dma_wdata = d;
    #1;
    while (!dma_gnt) begin
      @(negedge clk);
      #1;
    end
    if (we) ref_mem[a] = d;
    else    dma_q.push_back(ref_mem[a]);
    @(negedge clk);
    dma_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] p;
    int waited;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = DW'(i * 37 + 5);
      ref_mem[i] = DW'(i * 37 + 5);
    end

    // R1 reset
    repeat (3) @(negedge clk);
    chk(host_rdy == 1'b0, "R1 rdy in reset", 32'(host_rdy), 0);
    chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    waited = 0;
    do begin @(negedge clk); waited++; end while (!host_rdy && waited < 10);
    chk(waited == 2, "R1 rdy after reset prefetch", 32'(waited), 2);

    // R3 sequential reads from pointer 0
    for (int i = 0; i < 4; i++) host_read();

    // R4 cadence after a write
    wait_rdy();
    ref_mem[hp] = 16'hA5A5;
    hp = hp + 1'b1;
    host_wr = 1'b1; host_wdata = 16'hA5A5;
    @(negedge clk); host_wr = 1'b0; #1;
    chk(host_rdy == 1'b0, "R4 rdy low clk1", 32'(host_rdy), 0);
    @(negedge clk); #1;
    chk(host_rdy == 1'b0, "R4 rdy low clk2", 32'(host_rdy), 0);
    @(negedge clk); #1;
    chk(host_rdy == 1'b1, "R4 rdy high clk3", 32'(host_rdy), 1);
    chk(mem[4] == 16'hA5A5, "R2 write committed", 32'(mem[4]), 32'hA5A5);

    // R2 R8 write block then reread
    host_set(8'h20);
    for (int i = 0; i < 4; i++) host_write(DW'(16'h1000 + i));
    host_set(8'h20);
    for (int i = 0; i < 5; i++) host_read();

    // R8 pointer jump, R2 wrap
    host_set(8'h50);
    host_read();
    host_set(8'hFF);
    host_write(16'hBEEF);
    chk(hp == 8'h00, "R2 model wrap", 32'(hp), 0);
    host_read();
    host_set(8'hFF);
    host_read();

    // R8 pointer write while a prefetch is in flight
    wait_rdy();
    host_q.push_back(ref_mem[hp]);
    hp = hp + 1'b1;
    host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    host_addr_we = 1'b1; host_addr = 8'h60; hp = 8'h60;
    @(negedge clk); host_addr_we = 1'b0; #1;
    chk(host_rdy == 1'b0, "R8 rdy low after pointer write", 32'(host_rdy), 0);
    host_read();

    // R7 pointer back onto a still-posted write
    wait_rdy();
    p = hp;
    ref_mem[p] = 16'h7777;
    hp = hp + 1'b1;
    host_wr = 1'b1; host_wdata = 16'h7777;
    @(negedge clk); host_wr = 1'b0;
    host_addr_we = 1'b1; host_addr = p; hp = p;
    @(negedge clk); host_addr_we = 1'b0;
    host_read();

    // R9 strobe while busy
    host_set(8'h30);
    host_read();
    #1;
    chk(host_rdy == 1'b0, "R9 busy after read", 32'(host_rdy), 0);
    host_wr = 1'b1; host_wdata = 16'hDEAD;
    @(negedge clk); host_wr = 1'b0;
    host_read();
    chk(mem[8'h31] == ref_mem[8'h31], "R9 memory untouched", 32'(mem[8'h31]),
        32'(ref_mem[8'h31]));

    // R5 R6 collision cycle by cycle
    wait_rdy();
    ref_mem[hp] = 16'h5555;
    hp = hp + 1'b1;
    host_wr = 1'b1; host_wdata = 16'h5555;
    @(negedge clk); host_wr = 1'b0;
    dma_req = 1'b1; dma_we = 1'b0; dma_addr = 8'h20; #1;
    chk(dma_gnt == 1'b0 && mem_req == 1'b1, "R5 cpu wins fresh collision",
        32'(dma_gnt), 0);
    @(negedge clk); #1;
    chk(dma_gnt == 1'b1, "R6 held dma served next", 32'(dma_gnt), 1);
    dma_q.push_back(ref_mem[8'h20]);
    @(negedge clk);
    dma_addr = 8'h21; #1;
    chk(dma_gnt == 1'b0 && mem_req && mem_we, "R6 held cpu served next",
        32'(dma_gnt), 0);
    @(negedge clk); #1;
    chk(dma_gnt == 1'b1, "R6 dma after cpu", 32'(dma_gnt), 1);
    dma_q.push_back(ref_mem[8'h21]);
    @(negedge clk); dma_req = 1'b0;

    // R10 R6 concurrent traffic
    host_set(8'h40);
    fork
      begin
        for (int i = 0; i < 6; i++) host_read();
        for (int i = 0; i < 3; i++) host_write(DW'(16'h4400 + i));
      end
      begin
        for (int i = 0; i < 4; i++) dma_op(1'b1, AW'(8'h80 + i), DW'(16'h8000 + i));
        for (int i = 0; i < 6; i++) dma_op(1'b0, AW'(8'h20 + i), '0);
      end
    join
    host_set(8'h80);
    for (int i = 0; i < 4; i++) host_read();
    // R2 commits seen by the DMA path
    for (int i = 0; i < 3; i++) dma_op(1'b0, AW'(8'h46 + i), '0);
    dma_op(1'b0, 8'hFF, '0);

    repeat (4) @(negedge clk);
    chk(host_q.size() == 0, "R3 host scoreboard drained", 32'(host_q.size()), 0);
    chk(dma_q.size() == 0, "R10 dma scoreboard drained", 32'(dma_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule